// File: doc/BRIEF.md
# Dispatch Stall and Skid Controller

This block sits between register rename and the scheduling queues of an out-of-order core, one instance per hardware thread. Each cycle rename may hand it up to `REN_W` instructions. The block routes up to `DISP_W` of them to the issue queue, the load/store queue, a non-speculative path, or straight to completion. When a downstream stall is raised, it holds the arriving instructions in a skid FIFO. It tells rename to stop with a one-cycle block pulse and to resume with a one-cycle unblock pulse. Before it takes fresh input again, it drains everything it parked.

The controller has five named states:
- Running (code 0)
- Idle (code 1)
- Blocked (code 2)
- Unblocking (code 3)
- Squashing (code 4)

Its named transitions are:
- **squash-flush**: any state to Squashing on a commit squash.
- **rob-wait**: any state to Squashing while the reorder buffer is still squashing.
- **stall**: any state to Blocked on a stall source.
- **overflow-park**: Running or Idle to Blocked when more valid input arrives than the dispatch width.
- **begin-drain**: Blocked to Unblocking once the stall clears.
- **drain-done**: Unblocking to Running when the skid FIFO empties.
- **squash-done**: Squashing to Running.
- **go-idle / wake**: Running and Idle swap according to whether any input was valid.

Every instruction the block consumes is returned to rename as a credit, including instructions that are dropped. A second credit count covers the memory instructions among them.

Top module: `dispatch_skid_ctrl`

## Requirements
- R1: After reset the state output is Running (0), and every dispatch output, both credit counts and both pulses are 0.
- R2: A commit squash overrides every other condition. The skid FIFO and the current input are discarded, nothing is dispatched, and the state becomes Squashing (4) one cycle later.
- R3: On a commit squash, credit_all equals the number of skid entries plus the number of valid inputs discarded. credit_mem counts those with kind load (1), store (2) or store-conditional (3). unblock_up pulses exactly when the state was Blocked or Unblocking.
- R4: When the reorder buffer is still squashing (and no commit squash is present), the current input is discarded and credited, and the state becomes Squashing. From Squashing the controller takes the squash-done transition and dispatches normally in that same cycle.
- R5: Any of the four stall inputs moves the state to Blocked and appends all valid input to the skid FIFO without dispatching. The four inputs are commit stall, issue queue full, load/store queue full and load/store queue stall. block_up pulses only when the state was neither Blocked nor Unblocking.
- R6: Out of Blocked with no stall, the state becomes Unblocking and dispatch reads the oldest skid entries (up to DISP_W) in arrival order. Valid input arriving in that cycle is appended behind them.
- R7: When a drain cycle leaves the skid FIFO empty, unblock_up pulses and the state returns to Running in the same update. block_up and unblock_up are never high together.
- R8: In Running or Idle, input slots are dispatched in slot order up to DISP_W. Any valid slots beyond that are parked in the skid FIFO, the state becomes Blocked, block_up pulses and unblock_up stays low.
- R9: A dispatched entry marked dead uses a dispatch slot and is credited, but it raises no route output. Its tag is still shown.
- R10: Route outputs for a live entry follow its kind:
  - ALU (0): issue queue only.
  - load (1) or store (2): issue and load/store queues.
  - store-conditional (3): load/store queue and non-speculative path.
  - non-speculative (4): non-speculative path only.
  - nop (5): done only.
  - Codes 6 and 7 act as ALU.
- R11: Every output is registered and is due on the clock edge after the input cycle. Outputs last one cycle, and the credit counts cover exactly the entries consumed in that cycle.
- R12: Running or Idle with no valid input and no control condition leads to Idle. Any valid input leads to Running, unless the overflow-park transition applies.
- R13: The skid FIFO holds SKID_DEPTH = 3·DELAY·REN_W + ISSUE_W entries (11 by default). All of them are drained in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | REN_W | Valid per rename slot, filled from slot 0 |
| in_kind | input | 3·REN_W | Instruction kind per slot |
| in_dead | input | REN_W | Entry already squashed upstream |
| in_tag | input | TAG_W·REN_W | Instruction tag per slot |
| commit_squash | input | 1 | Squash from commit |
| rob_squashing | input | 1 | Reorder buffer still squashing |
| commit_stall | input | 1 | Stall raised by commit |
| iq_full | input | 1 | Issue queue full |
| lsq_full | input | 1 | Load/store queue full |
| lsq_stall | input | 1 | Load/store queue internal stall |
| out_iq | output | DISP_W | Slot goes to issue queue |
| out_lsq | output | DISP_W | Slot goes to load/store queue |
| out_nspec | output | DISP_W | Slot goes to non-speculative path |
| out_done | output | DISP_W | Slot marked complete |
| out_tag | output | TAG_W·DISP_W | Tag of each consumed slot, else 0 |
| credit_all | output | clog2(SKID_DEPTH+REN_W+1) | Entries consumed this cycle |
| credit_mem | output | clog2(SKID_DEPTH+REN_W+1) | Memory entries consumed this cycle |
| block_up | output | 1 | Block pulse to rename |
| unblock_up | output | 1 | Unblock pulse to rename |
| state | output | 3 | Current dispatch state |

## Verification
Every result is one register away from its stimulus. Routes, tags, credits, pulses and the new state all appear on the edge that follows the cycle in which the inputs were presented. The bench therefore drives inputs on a falling edge and checks exactly one rising edge later, on the next falling edge. Drain sequences are checked one falling edge per cycle, so each parked entry is compared in the cycle its turn comes up. The sweep over slot count, kind and dead pattern covers the overflow case too: it checks the overflow cycle and then the single drain cycle that follows it.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,
        ST_IDLE   = 3'd1,
        ST_BLOCK  = 3'd2,
        ST_UNBLK  = 3'd3,
        ST_SQUASH = 3'd4
    } dstate_e;

    localparam logic [2:0] K_ALU     = 3'd0;
    localparam logic [2:0] K_LOAD    = 3'd1;
    localparam logic [2:0] K_STORE   = 3'd2;
    localparam logic [2:0] K_STCOND  = 3'd3;
    localparam logic [2:0] K_NONSPEC = 3'd4;
    localparam logic [2:0] K_NOP     = 3'd5;

    function automatic logic is_mem(input logic [2:0] k);
        return (k == K_LOAD) || (k == K_STORE) || (k == K_STCOND);
    endfunction

endpackage

// File: rtl/dsc_skid_fifo.sv
module dsc_skid_fifo #(
    parameter int DEPTH  = 11,
    parameter int W      = 8,
    parameter int PUSH_N = 3,
    parameter int POP_N  = 2,
    parameter int CW     = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                flush,
    input  logic [CW-1:0]       push_cnt,
    input  logic [PUSH_N*W-1:0] push_data,
    input  logic [CW-1:0]       pop_cnt,
    output logic [POP_N*W-1:0]  head_data,
    output logic [DEPTH*W-1:0]  all_data,
    output logic [CW-1:0]       count
);
    logic [W-1:0]  mem_q [DEPTH];
    logic [W-1:0]  mem_d [DEPTH];
    logic [CW-1:0] cnt_q, cnt_d, rem;

    // Shift the survivors toward index 0, then append the pushed entries.
    always_comb begin
        rem   = cnt_q - pop_cnt;
        cnt_d = flush ? '0 : rem + push_cnt;
        for (int j = 0; j < DEPTH; j++) begin
            mem_d[j] = mem_q[j];
            if (CW'(j) < rem) begin
                for (int s = 0; s < DEPTH; s++)
                    if (CW'(s) == CW'(j) + pop_cnt) mem_d[j] = mem_q[s];
            end else begin
                for (int p = 0; p < PUSH_N; p++)
                    if ((CW'(p) + rem == CW'(j)) && (CW'(p) < push_cnt))
                        mem_d[j] = push_data[p*W +: W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int j = 0; j < DEPTH; j++) mem_q[j] <= '0;
        end else begin
            cnt_q <= cnt_d;
            for (int j = 0; j < DEPTH; j++) mem_q[j] <= mem_d[j];
        end
    end

    for (genvar j = 0; j < POP_N; j++) begin : g_head
        assign head_data[j*W +: W] = mem_q[j];
    end
    for (genvar j = 0; j < DEPTH; j++) begin : g_all
        assign all_data[j*W +: W] = mem_q[j];
    end
    assign count = cnt_q;

    // R13: the skid never pops more than it holds nor grows past its depth
    assert_skid_no_overflow_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |-> ((pop_cnt <= cnt_q) &&
                    (int'(cnt_q) - int'(pop_cnt) + int'(push_cnt) <= DEPTH)));

endmodule

// File: rtl/dsc_route_slot.sv
module dsc_route_slot
    import dsc_pkg::*;
(
    input  logic       valid,
    input  logic       dead,
    input  logic [2:0] kind,
    output logic       to_iq,
    output logic       to_lsq,
    output logic       to_nspec,
    output logic       to_done
);
    always_comb begin
        to_iq = 1'b0; to_lsq = 1'b0; to_nspec = 1'b0; to_done = 1'b0;
        if (valid && !dead) begin
            case (kind)
                K_LOAD, K_STORE: begin to_iq = 1'b1; to_lsq = 1'b1; end
                K_STCOND:        begin to_lsq = 1'b1; to_nspec = 1'b1; end
                K_NONSPEC:       to_nspec = 1'b1;
                K_NOP:           to_done = 1'b1;
                default:         to_iq = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/dispatch_skid_ctrl.sv
module dispatch_skid_ctrl
    import dsc_pkg::*;
#(
    parameter int DELAY      = 1,
    parameter int REN_W      = 3,
    parameter int DISP_W     = 2,
    parameter int ISSUE_W    = 2,
    parameter int TAG_W      = 4,
    parameter int SKID_DEPTH = 3 * DELAY * REN_W + ISSUE_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [REN_W-1:0]          in_valid,
    input  logic [3*REN_W-1:0]        in_kind,
    input  logic [REN_W-1:0]          in_dead,
    input  logic [TAG_W*REN_W-1:0]    in_tag,
    input  logic                      commit_squash,
    input  logic                      rob_squashing,
    input  logic                      commit_stall,
    input  logic                      iq_full,
    input  logic                      lsq_full,
    input  logic                      lsq_stall,
    output logic [DISP_W-1:0]         out_iq,
    output logic [DISP_W-1:0]         out_lsq,
    output logic [DISP_W-1:0]         out_nspec,
    output logic [DISP_W-1:0]         out_done,
    output logic [TAG_W*DISP_W-1:0]   out_tag,
    output logic [$clog2(SKID_DEPTH+REN_W+1)-1:0] credit_all,
    output logic [$clog2(SKID_DEPTH+REN_W+1)-1:0] credit_mem,
    output logic                      block_up,
    output logic                      unblock_up,
    output logic [2:0]                state
);
    localparam int CR_W = $clog2(SKID_DEPTH + REN_W + 1);
    localparam int EW   = 3 + 1 + TAG_W;   // {kind, dead, tag}

    dstate_e          state_q, e_state, nxt_state;
    logic [EW-1:0]    in_ent   [REN_W];
    logic [EW-1:0]    slot_ent [DISP_W];
    logic [CR_W-1:0]  in_cnt, skid_cnt, avail, take, push_cnt, push_off, pop_cnt;
    logic [CR_W-1:0]  cred_all_d, cred_mem_d;
    logic             stall_any, blocked_like, dispatching, from_skid;
    logic             flush, drop_in, drop_skid, blk_d, unblk_d;
    logic [REN_W*EW-1:0]      push_data;
    logic [DISP_W*EW-1:0]     skid_head;
    logic [SKID_DEPTH*EW-1:0] skid_all;
    logic [DISP_W-1:0]        r_iq, r_lsq, r_nspec, r_done;
    logic [TAG_W*DISP_W-1:0]  slot_tag;

    for (genvar i = 0; i < REN_W; i++) begin : g_in
        assign in_ent[i] = {in_kind[3*i +: 3], in_dead[i], in_tag[TAG_W*i +: TAG_W]};
    end

    always_comb begin
        in_cnt = '0;
        for (int i = 0; i < REN_W; i++) in_cnt = in_cnt + CR_W'(in_valid[i]);
    end

    assign stall_any    = commit_stall | iq_full | lsq_full | lsq_stall;
    assign blocked_like = (state_q == ST_BLOCK) || (state_q == ST_UNBLK);

    // Priority chain and next state
    always_comb begin
        e_state = state_q; nxt_state = state_q;
        dispatching = 1'b0; flush = 1'b0; drop_in = 1'b0; drop_skid = 1'b0;
        push_cnt = '0; push_off = '0; blk_d = 1'b0; unblk_d = 1'b0;
        if (commit_squash) begin
            flush = 1'b1; drop_in = 1'b1; drop_skid = 1'b1;
            unblk_d = blocked_like;
            nxt_state = ST_SQUASH;
        end else if (rob_squashing) begin
            drop_in = 1'b1;
            nxt_state = ST_SQUASH;
        end else if (stall_any) begin
            blk_d = !blocked_like;
            push_cnt = in_cnt;
            nxt_state = ST_BLOCK;
        end else begin
            unique case (state_q)
                ST_BLOCK, ST_UNBLK: e_state = ST_UNBLK;
                ST_SQUASH:          e_state = ST_RUN;
                ST_RUN, ST_IDLE:    e_state = state_q;
            endcase
            dispatching = 1'b1;
        end
        from_skid = dispatching && (e_state == ST_UNBLK);
        avail     = from_skid ? skid_cnt : in_cnt;
        take      = (avail > CR_W'(DISP_W)) ? CR_W'(DISP_W) : avail;
        pop_cnt   = from_skid ? take : '0;
        if (dispatching) begin
            if (from_skid) begin
                push_cnt = in_cnt;
                if (skid_cnt - take + in_cnt == '0) begin
                    unblk_d = 1'b1;
                    nxt_state = ST_RUN;
                end else begin
                    nxt_state = ST_UNBLK;
                end
            end else if (in_cnt > take) begin
                push_cnt = in_cnt - take;
                push_off = take;
                blk_d = 1'b1;
                nxt_state = ST_BLOCK;
            end else begin
                nxt_state = (in_cnt == '0) ? ST_IDLE : ST_RUN;
            end
        end
    end

    for (genvar j = 0; j < DISP_W; j++) begin : g_slot
        logic [EW-1:0] rn_ent;
        logic          s_valid;
        if (j < REN_W) begin : g_has_in
            assign rn_ent = in_ent[j];
        end else begin : g_no_in
            assign rn_ent = '0;
        end
        assign slot_ent[j] = from_skid ? skid_head[j*EW +: EW] : rn_ent;
        assign s_valid     = dispatching && (CR_W'(j) < take);
        assign slot_tag[j*TAG_W +: TAG_W] = s_valid ? slot_ent[j][TAG_W-1:0] : '0;

        dsc_route_slot u_route (
            .valid    (s_valid),
            .dead     (slot_ent[j][TAG_W]),
            .kind     (slot_ent[j][EW-1 -: 3]),
            .to_iq    (r_iq[j]),
            .to_lsq   (r_lsq[j]),
            .to_nspec (r_nspec[j]),
            .to_done  (r_done[j])
        );
    end

    // Push data selection and credit counting
    always_comb begin
        for (int i = 0; i < REN_W; i++) begin
            push_data[i*EW +: EW] = '0;
            for (int s = 0; s < REN_W; s++)
                if (CR_W'(s) == CR_W'(i) + push_off) push_data[i*EW +: EW] = in_ent[s];
        end
        cred_all_d = '0;
        cred_mem_d = '0;
        if (drop_skid) begin
            cred_all_d = cred_all_d + skid_cnt;
            for (int e = 0; e < SKID_DEPTH; e++)
                if ((CR_W'(e) < skid_cnt) && is_mem(skid_all[e*EW + EW - 1 -: 3]))
                    cred_mem_d = cred_mem_d + 1'b1;
        end
        if (drop_in) begin
            cred_all_d = cred_all_d + in_cnt;
            for (int i = 0; i < REN_W; i++)
                if (in_valid[i] && is_mem(in_kind[3*i +: 3])) cred_mem_d = cred_mem_d + 1'b1;
        end
        if (dispatching) begin
            cred_all_d = cred_all_d + take;
            for (int j = 0; j < DISP_W; j++)
                if ((CR_W'(j) < take) && is_mem(slot_ent[j][EW-1 -: 3]))
                    cred_mem_d = cred_mem_d + 1'b1;
        end
    end

    dsc_skid_fifo #(
        .DEPTH (SKID_DEPTH), .W (EW), .PUSH_N (REN_W), .POP_N (DISP_W), .CW (CR_W)
    ) u_skid (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push_cnt  (push_cnt),
        .push_data (push_data),
        .pop_cnt   (pop_cnt),
        .head_data (skid_head),
        .all_data  (skid_all),
        .count     (skid_cnt)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= nxt_state;
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_iq <= '0; out_lsq <= '0; out_nspec <= '0; out_done <= '0;
            out_tag <= '0; credit_all <= '0; credit_mem <= '0;
            block_up <= 1'b0; unblock_up <= 1'b0;
        end else begin
            out_iq <= r_iq; out_lsq <= r_lsq; out_nspec <= r_nspec; out_done <= r_done;
            out_tag <= slot_tag; credit_all <= cred_all_d; credit_mem <= cred_mem_d;
            block_up <= blk_d; unblock_up <= unblk_d;
        end
    end

    assign state = state_q;

    // R2: a commit squash always lands in Squashing
    assert_squash_enters_R2: assert property (@(posedge clk) disable iff (!rst_n)
        commit_squash |=> (state_q == ST_SQUASH) && (out_iq == '0) && (out_nspec == '0));

    // R5: a stall without squash lands in Blocked and consumes nothing
    assert_stall_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit_squash && !rob_squashing && stall_any) |=>
            (state_q == ST_BLOCK) && (credit_all == '0));

    // R7: the two upstream pulses are exclusive
    assert_pulse_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(block_up && unblock_up));

    // R7: an unblock pulse goes with Running or Squashing
    assert_unblock_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
        unblock_up |-> (state_q == ST_RUN) || (state_q == ST_SQUASH));

    // R8: a block pulse goes with Blocked
    assert_block_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
        block_up |-> (state_q == ST_BLOCK));

    // R12: no input and no control from Running leads to Idle
    assert_goes_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_RUN) && !commit_squash && !rob_squashing && !stall_any &&
         (in_valid == '0)) |=> (state_q == ST_IDLE));

    for (genvar j = 0; j < DISP_W; j++) begin : g_chk
        // R10: a slot never targets more than one of issue, non-spec, done
        assert_route_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0({out_iq[j], out_nspec[j], out_done[j]}));
    end

endmodule

// File: tb/dispatch_skid_ctrl_tb.sv
`timescale 1ns/1ps
module dispatch_skid_ctrl_tb;
    localparam int REN_W = 3, DISP_W = 2, TAG_W = 4;
    localparam int S_RUN = 0, S_IDLE = 1, S_BLOCK = 2, S_UNBLK = 3, S_SQUASH = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [REN_W-1:0] in_valid, in_dead;
    logic [3*REN_W-1:0] in_kind;
    logic [TAG_W*REN_W-1:0] in_tag;
    logic commit_squash, rob_squashing, commit_stall, iq_full, lsq_full, lsq_stall;
    logic [DISP_W-1:0] out_iq, out_lsq, out_nspec, out_done;
    logic [TAG_W*DISP_W-1:0] out_tag;
    logic [3:0] credit_all, credit_mem;
    logic block_up, unblock_up;
    logic [2:0] state;

    int tests = 0, fails = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    dispatch_skid_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
        .in_dead(in_dead), .in_tag(in_tag), .commit_squash(commit_squash),
        .rob_squashing(rob_squashing), .commit_stall(commit_stall), .iq_full(iq_full),
        .lsq_full(lsq_full), .lsq_stall(lsq_stall), .out_iq(out_iq), .out_lsq(out_lsq),
        .out_nspec(out_nspec), .out_done(out_done), .out_tag(out_tag),
        .credit_all(credit_all), .credit_mem(credit_mem), .block_up(block_up),
        .unblock_up(unblock_up), .state(state)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_in();
        in_valid = '0; in_dead = '0; in_kind = '0; in_tag = '0;
    endtask

    task automatic clear_ctl();
        commit_squash = 0; rob_squashing = 0; commit_stall = 0;
        iq_full = 0; lsq_full = 0; lsq_stall = 0;
    endtask

    task automatic put(input int i, input int k, input int d, input int t);
        in_valid[i] = 1'b1;
        in_kind[3*i +: 3] = 3'(k);
        in_dead[i] = 1'(d);
        in_tag[TAG_W*i +: TAG_W] = 4'(t);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int tag_at(int j);
        return int'(out_tag[TAG_W*j +: TAG_W]);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        clear_in(); clear_ctl();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", "state", state, S_RUN);
        chk("R1", "outputs", int'({out_iq, out_lsq, out_nspec, out_done, out_tag}), 0);
        chk("R1", "credits", int'({credit_all, credit_mem}), 0);
        chk("R1", "pulses", int'({block_up, unblock_up}), 0);

        // Sweep: slot count x kind x dead pattern from Running/Idle (R8 R9 R10 R11 R12)
        for (int n = 0; n <= 3; n++) begin
            for (int k = 0; k <= 5; k++) begin
                for (int dm = 0; dm < 8; dm++) begin
                    int take, mem, ei, el, en, ed, et;
                    clear_in();
                    for (int j = 0; j < n; j++) put(j, k, (dm >> j) & 1, (n + j + k + dm) & 15);
                    take = (n > 2) ? 2 : n;
                    mem = (k >= 1 && k <= 3) ? 1 : 0;
                    step();
                    chk("R11", "credit_all", credit_all, take);
                    chk("R11", "credit_mem", credit_mem, mem * take);
                    chk("R12", "state", state, (n > 2) ? S_BLOCK : (n == 0 ? S_IDLE : S_RUN));
                    chk("R8", "block_up", block_up, (n > 2) ? 1 : 0);
                    chk("R8", "unblock_up", unblock_up, 0);
                    ei = 0; el = 0; en = 0; ed = 0; et = 0;
                    for (int j = 0; j < take; j++) begin
                        int live;
                        live = ((dm >> j) & 1) == 0;
                        et |= ((n + j + k + dm) & 15) << (TAG_W * j);
                        if (live) begin
                            if (k <= 2) ei |= 1 << j;
                            if (k >= 1 && k <= 3) el |= 1 << j;
                            if (k == 3 || k == 4) en |= 1 << j;
                            if (k == 5) ed |= 1 << j;
                        end
                    end
                    chk("R10", "out_iq", out_iq, ei);
                    chk("R10", "out_lsq", out_lsq, el);
                    chk("R10", "out_nspec", out_nspec, en);
                    chk("R9", "out_done", out_done, ed);
                    chk("R9", "out_tag", out_tag, et);
                    if (n > 2) begin
                        clear_in();
                        step();
                        // R7: single parked entry drains, unblock and Running
                        chk("R7", "drain state", state, S_RUN);
                        chk("R7", "unblock_up", unblock_up, 1);
                        chk("R6", "drain tag", tag_at(0), (n + 2 + k + dm) & 15);
                        chk("R9", "drain iq", out_iq[0], (((dm >> 2) & 1) == 0 && k <= 2) ? 1 : 0);
                        chk("R11", "drain credit", credit_all, 1);
                    end
                end
            end
        end

        // R5: each stall source alone
        for (int s = 0; s < 4; s++) begin
            clear_in();
            put(0, 0, 0, 9 + s);
            commit_stall = (s == 0); iq_full = (s == 1); lsq_full = (s == 2); lsq_stall = (s == 3);
            step();
            chk("R5", "src block_up", block_up, 1);
            chk("R5", "src state", state, S_BLOCK);
            chk("R5", "src no dispatch", out_iq, 0);
            clear_in(); clear_ctl();
            step();
            chk("R7", "src unblock", unblock_up, 1);
            chk("R6", "src tag", tag_at(0), 9 + s);
            chk("R7", "src state", state, S_RUN);
        end

        // R5/R6: repeated stall, then drain with appended input
        clear_in(); iq_full = 1;
        put(0, 0, 0, 1); put(1, 0, 0, 2); put(2, 0, 0, 3);
        step();
        chk("R5", "first block_up", block_up, 1);
        clear_in(); put(0, 0, 0, 4); put(1, 0, 0, 5);
        step();
        chk("R5", "second block_up", block_up, 0);
        chk("R5", "still blocked", state, S_BLOCK);
        clear_in(); clear_ctl();
        step();
        chk("R6", "unblk state", state, S_UNBLK);
        chk("R6", "tags 1,2", int'(out_tag), 1 | (2 << 4));
        chk("R6", "no unblock yet", unblock_up, 0);
        put(0, 0, 0, 6);
        step();
        chk("R6", "tags 3,4", int'(out_tag), 3 | (4 << 4));
        chk("R6", "still unblk", state, S_UNBLK);
        clear_in();
        step();
        chk("R6", "tags 5,6", int'(out_tag), 5 | (6 << 4));
        chk("R7", "drain unblock", unblock_up, 1);
        chk("R7", "drain running", state, S_RUN);

        // R2/R3: squash while Blocked
        clear_in(); lsq_full = 1;
        put(0, 1, 0, 1); put(1, 1, 0, 2); put(2, 0, 0, 3);
        step();
        clear_in(); clear_ctl(); commit_squash = 1;
        put(0, 2, 0, 4); put(1, 5, 0, 5);
        step();
        chk("R3", "squash credit_all", credit_all, 5);
        chk("R3", "squash credit_mem", credit_mem, 3);
        chk("R3", "squash unblock", unblock_up, 1);
        chk("R2", "squash state", state, S_SQUASH);
        chk("R2", "squash no dispatch", int'({out_iq, out_lsq, out_done}), 0);
        clear_in(); clear_ctl();
        step();
        chk("R4", "after squash idle", state, S_IDLE);
        chk("R2", "skid flushed", credit_all, 0);
        put(0, 0, 0, 7);
        step();
        chk("R2", "direct dispatch tag", tag_at(0), 7);
        chk("R2", "direct running", state, S_RUN);

        // R4: reorder buffer still squashing
        clear_in(); rob_squashing = 1;
        put(0, 1, 0, 1); put(1, 0, 0, 2); put(2, 0, 1, 3);
        step();
        chk("R4", "rob credit_all", credit_all, 3);
        chk("R4", "rob credit_mem", credit_mem, 1);
        chk("R4", "rob state", state, S_SQUASH);
        chk("R4", "rob pulses", int'({block_up, unblock_up}), 0);
        clear_in(); clear_ctl(); put(0, 3, 0, 8);
        step();
        chk("R4", "squash-done state", state, S_RUN);
        chk("R10", "stcond routes", int'({out_iq[0], out_lsq[0], out_nspec[0]}), 3);
        chk("R11", "stcond mem credit", credit_mem, 1);

        // R2: commit squash beats stall
        clear_in(); commit_squash = 1; commit_stall = 1;
        put(0, 0, 0, 1); put(1, 0, 0, 2);
        step();
        chk("R2", "prio state", state, S_SQUASH);
        chk("R2", "prio no block", block_up, 0);
        chk("R3", "prio no unblock", unblock_up, 0);
        chk("R3", "prio credit", credit_all, 2);
        clear_in(); clear_ctl();
        step();

        // R13: fill all 11 skid entries, drain in order
        commit_stall = 1;
        for (int c = 0; c < 4; c++) begin
            clear_in();
            for (int j = 0; j < ((c < 3) ? 3 : 2); j++) put(j, 0, 0, c * 3 + j);
            step();
        end
        clear_in(); clear_ctl();
        for (int c = 0; c < 6; c++) begin
            step();
            chk("R13", "fill tag0", tag_at(0), 2 * c);
            if (c < 5) chk("R13", "fill tag1", tag_at(1), 2 * c + 1);
            chk("R13", "fill state", state, (c < 5) ? S_UNBLK : S_RUN);
            chk("R13", "fill unblock", unblock_up, (c < 5) ? 0 : 1);
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule